// File: doc/BRIEF.md
# Synchronous Peripheral Bus Cycle Adapter

This block lets a fast processor bus talk to slow peripherals that need their transfers lined up with a steady, low-rate enable clock. It divides the system clock down into a free-running enable waveform. On every clock the block also watches for the start of a processor bus cycle. One clock after a start, it samples an active-low request line. An address decoder drives this line low when the address belongs to a slow peripheral.

If the request is inactive, the cycle is let through as an ordinary fast cycle. If it is active, the block waits for the enable to be low and then asserts an active-low valid-memory-address strobe. It holds that strobe across one complete enable-high phase and finishes the transfer on the enable falling edge that ends that phase. On reads it gives a one-clock data-latch pulse in the last high clock. Because the enable waveform never stops, the length of a synchronous cycle depends on where in the enable period the processor cycle began.

Top module: `sync_bus_adapter`

## Requirements
- R1: `en_o` is periodic with a period of DIV_CLKS clocks (default 10). In each period it is low for LOW_CLKS clocks (default 6) and then high for the remaining DIV_CLKS-LOW_CLKS clocks (default 4).
- R2: While `rst_n` is low, `en_o` is low, `vma_n_o` is high, and `latch_o` and `done_o` are low. After release the enable waveform starts at the beginning of its low phase.
- R3: If `vpa_n_i` is 1 in the clock after the start pulse (clock index 1, where the start pulse is at index 0), the cycle is fast. `done_o` is high for exactly one clock at index 2, and `vma_n_o` stays high for the whole cycle.
- R4: If `vpa_n_i` is 0 at index 1, the cycle is synchronous. `vma_n_o` goes low in the first clock, counting from index 3, in which `en_o` is low.
- R5: During a synchronous cycle, `vma_n_o` only ever falls while `en_o` is low. It then stays low through exactly one complete enable-high phase (4 clocks with defaults).
- R6: In a synchronous cycle, `done_o` is high for exactly one clock: the first clock in which `en_o` is low again after that high phase. `vma_n_o` is back high in that same clock.
- R7: When `rw_i` was 1 at the start pulse (read), `latch_o` is high for exactly one clock of a synchronous cycle: the last clock of the enable-high phase. On a write (`rw_i` = 0) and on fast cycles, `latch_o` stays low.
- R8: A start pulse that arrives while a cycle is in progress is ignored. It produces no second `done_o`.
- R9: `vpa_n_i` is sampled only at index 1. Changing it later in the cycle has no effect on the timing of `vma_n_o`, `latch_o` or `done_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| as_start_i | input | 1 | One-clock pulse marking the start of a processor bus cycle |
| rw_i | input | 1 | Transfer direction captured at the start pulse: 1 read, 0 write |
| vpa_n_i | input | 1 | Active-low request for a synchronous peripheral cycle |
| en_o | output | 1 | Free-running peripheral enable clock |
| vma_n_o | output | 1 | Active-low valid-memory-address strobe for the peripheral |
| latch_o | output | 1 | One-clock read data latch pulse |
| done_o | output | 1 | One-clock cycle completion indication |

## Verification
The bench builds the block with its default division of 10 clocks and a 6-clock low phase. With these values every one of the ten possible start phases can be reached, so the walk covers both the shortest synchronous cycle (done 8 clocks after the start) and the longest (done 17 clocks after). It also covers starts that land just before and just after the enable rises, which is where the wait for a low phase switches between no wait and a full wait. Reads and writes, fast cycles, a request line that flips after the decision point, stray start pulses during a cycle, and a reset in the middle of a cycle are each driven at known phases.

// File: rtl/sba_pkg.sv
package sba_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DECIDE = 3'd1,
    ST_FAST   = 3'd2,
    ST_WAIT   = 3'd3,
    ST_SYNC   = 3'd4,
    ST_DONE   = 3'd5
  } sba_state_e;
endpackage

// File: rtl/sba_phase_gen.sv
module sba_phase_gen #(
  parameter int DIV_CLKS = 10,
  parameter int LOW_CLKS = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic en_o,
  output logic low_next_o,
  output logic last_high_o
);
  localparam int PW = (DIV_CLKS > 1) ? $clog2(DIV_CLKS) : 1;
  localparam logic [PW-1:0] LAST_PH = PW'(DIV_CLKS - 1);
  localparam logic [PW-1:0] HIGH_PH = PW'(LOW_CLKS);

  logic [PW-1:0] ph_q, ph_d;

  always_comb begin
    if (ph_q == LAST_PH) ph_d = '0;
    else                 ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign en_o        = (ph_q >= HIGH_PH);
  assign low_next_o  = (ph_d < HIGH_PH);
  assign last_high_o = (ph_q == LAST_PH);

  AST_PH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != '0) |-> (ph_q == $past(ph_q) + 1'b1)); // R1
  AST_EN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_o) |-> (ph_q == HIGH_PH)); // R1
endmodule

// File: rtl/sba_cycle_fsm.sv
module sba_cycle_fsm
  import sba_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic rw_i,
  input  logic vpa_n_i,
  input  logic en_i,
  input  logic low_next_i,
  input  logic last_high_i,
  output logic vma_n_o,
  output logic latch_o,
  output logic done_o
);
  sba_state_e state_q, state_d;
  logic       rd_q;
  logic       rd_load;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_DECIDE;
      ST_DECIDE: state_d = vpa_n_i ? ST_FAST : ST_WAIT;
      ST_FAST:   state_d = ST_IDLE;
      ST_WAIT:   if (low_next_i) state_d = ST_SYNC;
      ST_SYNC:   if (last_high_i) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign rd_load = (state_q == ST_IDLE) && start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= 1'b0;
    else if (rd_load) rd_q <= rw_i;
  end

  assign vma_n_o = (state_q != ST_SYNC);
  assign latch_o = (state_q == ST_SYNC) && last_high_i && rd_q;
  assign done_o  = (state_q == ST_DONE) || (state_q == ST_FAST);

  AST_VMA_FALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vma_n_o) |-> !en_i); // R5
  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !$past(vma_n_o)) |-> ($fell(en_i) && vma_n_o)); // R6
  AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R3
  AST_LATCH_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    latch_o |-> (en_i && !vma_n_o)); // R7
  AST_VMA_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!vma_n_o && en_i) |=> (!vma_n_o || !en_i)); // R5
endmodule

// File: rtl/sync_bus_adapter.sv
module sync_bus_adapter #(
  parameter int DIV_CLKS = 10,
  parameter int LOW_CLKS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic as_start_i,
  input  logic rw_i,
  input  logic vpa_n_i,
  output logic en_o,
  output logic vma_n_o,
  output logic latch_o,
  output logic done_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       low_next;
  logic       last_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sba_phase_gen #(
    .DIV_CLKS(DIV_CLKS),
    .LOW_CLKS(LOW_CLKS)
  ) phase_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .en_o       (en_o),
    .low_next_o (low_next),
    .last_high_o(last_high)
  );

  sba_cycle_fsm fsm_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (as_start_i),
    .rw_i       (rw_i),
    .vpa_n_i    (vpa_n_i),
    .en_i       (en_o),
    .low_next_i (low_next),
    .last_high_i(last_high),
    .vma_n_o    (vma_n_o),
    .latch_o    (latch_o),
    .done_o     (done_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (vma_n_o && !done_o && !en_o)); // R2
endmodule

// File: tb/sync_bus_adapter_tb_top.sv
module sync_bus_adapter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 10;
  localparam int LOWC = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic as_start = 1'b0;
  logic rw = 1'b0;
  logic vpa_n = 1'b1;
  logic en, vma_n, latch, done;

  int checks = 0;
  int errs = 0;
  int cyc = 0;
  int cyc0 = 0;

  // start phase [5:2], vpa_n [1], rw [0]
  localparam logic [5:0] VEC [12] = '{
    {4'd0, 1'b0, 1'b1}, {4'd1, 1'b0, 1'b0}, {4'd2, 1'b0, 1'b1},
    {4'd3, 1'b0, 1'b1}, {4'd4, 1'b0, 1'b0}, {4'd5, 1'b0, 1'b1},
    {4'd6, 1'b0, 1'b1}, {4'd7, 1'b0, 1'b0}, {4'd8, 1'b0, 1'b1},
    {4'd9, 1'b0, 1'b1}, {4'd3, 1'b1, 1'b1}, {4'd7, 1'b1, 1'b0}
  };

  sync_bus_adapter #(.DIV_CLKS(DIV), .LOW_CLKS(LOWC)) dut_i (
    .clk(clk), .rst_n(rst_n), .as_start_i(as_start), .rw_i(rw),
    .vpa_n_i(vpa_n), .en_o(en), .vma_n_o(vma_n), .latch_o(latch), .done_o(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int phase();
    return (cyc - cyc0) % DIV;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // find the clock in which en has just fallen: that clock is phase 0
  task automatic align();
    logic prev;
    prev = en;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (prev && !en) begin
        cyc0 = cyc;
        return;
      end
      prev = en;
    end
  endtask

  task automatic run_cycle(int s, logic v, logic r, bit extra);
    int first_done, n_done, n_vma, n_vma_hi, n_latch, latch_idx;
    int p, d_exp, vma_exp;
    string tg;
    first_done = -1; n_done = 0; n_vma = 0; n_vma_hi = 0; n_latch = 0; latch_idx = -1;
    while (phase() != s) @(negedge clk);
    as_start = 1'b1; rw = r; vpa_n = v;
    for (int i = 1; i <= 24; i++) begin
      @(negedge clk);
      if (done) begin n_done++; if (first_done < 0) first_done = i; end
      if (!vma_n) begin n_vma++; if (en) n_vma_hi++; end
      if (latch) begin n_latch++; latch_idx = i; end
      as_start = extra && (i == 3 || i == 10);
      if (i == 2) vpa_n = ~v;   // R9: flip after the decision clock
      if (i == 1) rw = ~r;
    end
    vpa_n = 1'b1;
    p = (s + 2) % DIV;
    if (v) begin d_exp = 2; vma_exp = 0; end
    else if (p <= 4) begin d_exp = 12 - p; vma_exp = 9 - p; end
    else begin d_exp = 22 - p; vma_exp = 10; end
    tg = v ? "R3" : "R4/R6/R9";
    chk({tg, " done index"}, first_done, d_exp);
    chk(extra ? "R8 done count" : "R6 done count", n_done, 1);
    chk(v ? "R3 vma low clocks" : "R4 vma low clocks", n_vma, vma_exp);
    chk("R5 vma low during en high", n_vma_hi, v ? 0 : 4);
    chk("R7 latch count", n_latch, (!v && r) ? 1 : 0);
    if (!v && r) chk("R7 latch index", latch_idx, d_exp - 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int mism, highs;
    // R2: outputs while reset held
    repeat (3) @(negedge clk);
    chk("R2 en in reset", en, 0);
    chk("R2 vma_n in reset", vma_n, 1);
    chk("R2 latch/done in reset", latch | done, 0);
    rst_n = 1'b1;
    align();
    // R1: waveform over three periods
    mism = 0; highs = 0;
    for (int k = 0; k < 3 * DIV; k++) begin
      if (en != (phase() >= LOWC)) mism++;
      if (en) highs++;
      @(negedge clk);
    end
    chk("R1 en shape mismatches", mism, 0);
    chk("R1 en high clocks", highs, 3 * (DIV - LOWC));
    // table walk
    foreach (VEC[j])
      run_cycle(int'(VEC[j][5:2]), VEC[j][1], VEC[j][0], 1'b0);
    // R8: stray starts during a synchronous read
    run_cycle(5, 1'b0, 1'b1, 1'b1);
    run_cycle(0, 1'b0, 1'b0, 1'b1);
    // R2: reset in the middle of a synchronous cycle
    while (phase() != 2) @(negedge clk);
    as_start = 1'b1; vpa_n = 1'b0; rw = 1'b1;
    @(negedge clk); as_start = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 vma low before mid reset", vma_n, 0);
    rst_n = 1'b0;
    #1;
    chk("R2 vma_n after mid reset", vma_n, 1);
    chk("R2 en after mid reset", en, 0);
    chk("R2 done after mid reset", done, 0);
    vpa_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    // after release the first en rise comes LOW clocks after the phase restarts
    align();
    chk("R2 en low at phase 0", en, 0);
    run_cycle(9, 1'b0, 1'b1, 1'b0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule